// File: doc/BRIEF.md
# Pretrace-Back Survivor Memory Unit

This block holds the survivor history of a 32-state, rate-1/2 convolutional decoder whose add-compare-select array handles two trellis stages per iteration. Each iteration delivers one 2-bit decision for every state. The block combines every two consecutive decision sets into a single 4-bit decision per state. A 4-bit decision spans four single-bit trellis stages, so each trace-back step jumps back four stages at once.

The combined rows go into a single-ported cyclic decision memory. The same port serves the trace-back reads. A row write always wins the port, and reads fill the cycles between writes. A trace-back session starts from a state supplied by the caller and from the newest stored row. It walks backward for a fixed settling length and then decodes a fixed number of rows. The bits recovered during that walk come out in reverse time order, so a small stack returns them to time order before they leave the block, four at a time.

Top module: `smu_pretrace`

## Requirements
- R1: Decision sets accepted with `acs_valid` form pairs, counted from reset: first an older set A, then a newer set B. For a state s with B's 2-bit decision d1 = B[2s+1:2s], the intermediate state is q = {s[2:0], d1}, and the stored 4-bit entry for s is {d1, A[2q+1:2q]}, held at row bits [4s+3:4s].
- R2: Each completed pair writes exactly one row. The write address starts at 0 after reset, advances by one per row and wraps from DEPTH-1 to 0.
- R3: The memory port performs at most one access per cycle. A row write takes priority and a trace-back read is issued only in a cycle without a write, so a session completes even while rows arrive at the highest possible rate (one row every two cycles).
- R4: `tb_start` sampled while idle captures `tb_state` and begins the walk at the row most recently written before that clock edge. Each later read addresses the row one older, wrapping from 0 to DEPTH-1.
- R5: One trace-back step from state s with the entry e = row[4s+3:4s] moves to state {s[0], e[3:0]}.
- R6: The first TB_ROWS steps of a session yield no output. Each of the next DEC_ROWS steps yields the four bits s[4:1] of the state s in use before that step.
- R7: A session emits exactly DEC_ROWS nibbles on `bits` with `bits_valid` high, in time order: the nibble from the oldest decoded row comes first. Within a nibble, bit 0 belongs to the oldest trellis stage and bit 3 to the newest.
- R8: `tb_start` has no effect while `tb_busy` is high, and the running session's outputs are unchanged.
- R9: After reset `tb_busy` and `bits_valid` are low and no pair is half formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acs_valid | input | 1 | A decision set is present on `acs_dec` |
| acs_dec | input | 64 | 2-bit decision per state, state s at bits [2s+1:2s] |
| tb_start | input | 1 | Request a trace-back session |
| tb_state | input | 5 | State that the walk starts from |
| tb_busy | output | 1 | A session is in progress |
| bits_valid | output | 1 | A decoded nibble is present on `bits` |
| bits | output | 4 | Four decoded bits, bit 0 the oldest |

## Verification
The assertions assume that a session only starts once at least TB_ROWS+DEC_ROWS rows have been written. They also assume that DEPTH leaves enough margin that rows arriving during a walk never overwrite a row still to be read. The stimulus requests a session only after enough rows exist, and it keeps DEPTH at 32 against a 12-row walk. Decision inputs are random, arriving at full rate or with random gaps, and the pairing the assertions rely on always begins from reset. Requests arriving while busy are issued on purpose, with a different start state.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int STATE_W = 5;
  localparam int NSTATE  = 1 << STATE_W;
  localparam int DEC_W   = 2 * NSTATE;
  localparam int ROW_W   = 4 * NSTATE;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [DEC_W-1:0]   dec_vec_t;
  typedef logic [ROW_W-1:0]   row_t;
  typedef enum logic [1:0] {PH_IDLE, PH_WALK, PH_DRAIN} tb_phase_e;

  // one radix-4 step backward: two new low bits come from the decision
  function automatic state_t pred_r4(state_t s, logic [1:0] d);
    return {s[STATE_W-3:0], d};
  endfunction

  // one radix-16 step backward: four stages at once
  function automatic state_t pred_r16(state_t s, logic [3:0] e);
    return {s[STATE_W-5:0], e};
  endfunction

  // the four input bits that a radix-16 step drops off the top
  function automatic logic [3:0] shed_bits(state_t s);
    return s[STATE_W-1:STATE_W-4];
  endfunction

  function automatic logic [3:0] pick_entry(row_t r, state_t s);
    return r[4*s +: 4];
  endfunction

  // lookahead merge of an older and a newer decision set
  function automatic row_t merge_pair(dec_vec_t older, dec_vec_t newer);
    row_t r;
    state_t q;
    logic [1:0] d1;
    r = '0;
    for (int s = 0; s < NSTATE; s++) begin
      d1 = newer[2*s +: 2];
      q  = pred_r4(state_t'(s), d1);
      r[4*s +: 4] = {d1, older[2*q +: 2]};
    end
    return r;
  endfunction
endpackage

// File: rtl/smu_merge.sv
module smu_merge
  import smu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  dec_vec_t in_dec,
  output logic     row_we,
  output row_t     row_data
);
  dec_vec_t held_q;
  logic     second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      held_q   <= '0;
    end else if (in_valid) begin
      if (!second_q) held_q <= in_dec;
      second_q <= ~second_q;
    end
  end

  assign row_we   = in_valid & second_q;
  assign row_data = merge_pair(held_q, in_dec);
endmodule

// File: rtl/smu_ram.sv
module smu_ram
  import smu_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  row_t          wdata,
  output row_t          rdata
);
  row_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    else if (re) rdata <= store[addr];
  end
endmodule

// File: rtl/smu_lifo.sv
module smu_lifo #(
  parameter int DEPTH = 4,
  parameter int W = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] stk [DEPTH];
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(cnt);
  assign top_idx = IW'(cnt - CW'(1));
  assign top     = (cnt == '0) ? '0 : stk[top_idx];

  always_ff @(posedge clk) begin
    if (push) stk[wr_idx] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop && cnt != '0) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/smu_pretrace.sv
module smu_pretrace
  import smu_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int TB_ROWS  = 8,
  parameter int DEC_ROWS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acs_valid,
  input  logic [DEC_W-1:0]    acs_dec,
  input  logic                tb_start,
  input  logic [STATE_W-1:0]  tb_state,
  output logic                tb_busy,
  output logic                bits_valid,
  output logic [3:0]          bits
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TOTAL = TB_ROWS + DEC_ROWS;
  localparam int NW    = $clog2(TOTAL + 1);
  localparam int CW    = $clog2(DEC_ROWS + 1);

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_prev(logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  // named internal events
  logic          mem_we, mem_re, rd_pend, start_ok;
  logic          lifo_push, lifo_pop;
  logic [AW-1:0] wr_ptr, rd_ptr, mem_addr;
  logic [CW-1:0] lifo_cnt;
  logic [3:0]    lifo_top, step_e;
  logic [NW-1:0] issued, stepped;
  row_t          row_wdata, row_rdata;
  state_t        cur_state;
  tb_phase_e     phase;

  smu_merge u_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(acs_valid), .in_dec(acs_dec),
    .row_we(mem_we), .row_data(row_wdata)
  );

  assign start_ok = tb_start && (phase == PH_IDLE);
  assign mem_re   = (phase == PH_WALK) && (issued != NW'(TOTAL)) && !mem_we;
  assign mem_addr = mem_we ? wr_ptr : rd_ptr;

  smu_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(row_wdata), .rdata(row_rdata)
  );

  assign step_e    = pick_entry(row_rdata, cur_state);
  assign lifo_push = rd_pend && (stepped >= NW'(TB_ROWS));
  assign lifo_pop  = (phase == PH_DRAIN);

  smu_lifo #(.DEPTH(DEC_ROWS), .W(4)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(lifo_push), .pop(lifo_pop),
    .din(shed_bits(cur_state)), .top(lifo_top), .cnt(lifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else if (mem_we) wr_ptr <= ptr_next(wr_ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      rd_ptr    <= '0;
      issued    <= '0;
      stepped   <= '0;
      cur_state <= '0;
      rd_pend   <= 1'b0;
    end else begin
      rd_pend <= mem_re;
      unique case (phase)
        PH_IDLE: if (start_ok) begin
          phase     <= PH_WALK;
          cur_state <= tb_state;
          rd_ptr    <= ptr_prev(wr_ptr);
          issued    <= '0;
          stepped   <= '0;
        end
        PH_WALK: begin
          if (mem_re) begin
            rd_ptr <= ptr_prev(rd_ptr);
            issued <= issued + NW'(1);
          end
          if (rd_pend) begin
            cur_state <= pred_r16(cur_state, step_e);
            stepped   <= stepped + NW'(1);
            if (stepped == NW'(TOTAL - 1)) phase <= PH_DRAIN;
          end
        end
        PH_DRAIN: if (lifo_cnt == CW'(1)) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign tb_busy    = (phase != PH_IDLE);
  assign bits_valid = (phase == PH_DRAIN);
  assign bits       = lifo_top;
endmodule

// File: rtl/smu_pretrace_chk.sv
module smu_pretrace_chk #(
  parameter int DEPTH    = 32,
  parameter int TB_ROWS  = 8,
  parameter int DEC_ROWS = 4,
  parameter int AW       = 5,
  parameter int CW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tb_start,
  input logic          tb_busy,
  input logic          bits_valid,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] lifo_cnt
);
  localparam int TOTAL = TB_ROWS + DEC_ROWS;

  function automatic logic [AW-1:0] up1(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] dn1(logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  logic [15:0]   rd_cnt, out_cnt;
  logic [AW-1:0] last_ra;
  logic          have_ra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      out_cnt <= '0;
      last_ra <= '0;
      have_ra <= 1'b0;
    end else if (!tb_busy) begin
      rd_cnt  <= '0;
      out_cnt <= '0;
      have_ra <= 1'b0;
    end else begin
      if (mem_re) begin
        rd_cnt  <= rd_cnt + 16'd1;
        last_ra <= rd_ptr;
        have_ra <= 1'b1;
      end
      if (bits_valid) out_cnt <= out_cnt + 16'd1;
    end
  end

  a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (wr_ptr == up1($past(wr_ptr))));
  a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(wr_ptr));
  a_r4_back_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && have_ra) |-> (rd_ptr == dn1(last_ra)));
  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tb_busy) |-> $past(tb_start));
  a_r3_read_total: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tb_busy) |-> (rd_cnt == 16'(TOTAL)));
  a_r7_out_total: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tb_busy) |-> (out_cnt == 16'(DEC_ROWS)));
  a_r7_out_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bits_valid |-> tb_busy);
  a_r6_lifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lifo_cnt <= CW'(DEC_ROWS));
endmodule

bind smu_pretrace smu_pretrace_chk #(
  .DEPTH(DEPTH), .TB_ROWS(TB_ROWS), .DEC_ROWS(DEC_ROWS), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_start(tb_start), .tb_busy(tb_busy),
  .bits_valid(bits_valid), .mem_we(mem_we), .mem_re(mem_re),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .lifo_cnt(lifo_cnt)
);

// File: tb/tb_smu_pretrace.sv
module tb_smu_pretrace;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 32;
  localparam int TB     = 8;
  localparam int DEC    = 4;
  localparam int TOTAL  = TB + DEC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acs_valid = 1'b0;
  logic [63:0] acs_dec = '0;
  logic        tb_start = 1'b0;
  logic [4:0]  tb_state = '0;
  logic        tb_busy, bits_valid;
  logic [3:0]  bits;

  always #(CLK_NS/2) clk = ~clk;

  smu_pretrace #(.DEPTH(DEPTH), .TB_ROWS(TB), .DEC_ROWS(DEC)) dut (
    .clk(clk), .rst_n(rst_n), .acs_valid(acs_valid), .acs_dec(acs_dec),
    .tb_start(tb_start), .tb_state(tb_state), .tb_busy(tb_busy),
    .bits_valid(bits_valid), .bits(bits)
  );

  int total = 0, bad = 0;
  logic [127:0] rows [0:4095];
  int nrows = 0;
  logic half = 1'b0;
  logic [63:0] held = '0;
  int exp_nib [DEC];
  int got = 0;
  logic prev_busy = 1'b0;
  string cur_tag = "R1 R5 R6";
  string sess_tag = "R1 R5 R6";

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // entry for s: newer decision d1, then older decision at the intermediate state
  function automatic logic [127:0] b_merge(logic [63:0] a, logic [63:0] b);
    logic [127:0] r = '0;
    for (int s = 0; s < 32; s++) begin
      int d1 = int'(b[2*s +: 2]);
      int q  = (s * 4 + d1) % 32;
      r[4*s +: 4] = 4'(d1 * 4 + int'(a[2*q +: 2]));
    end
    return r;
  endfunction

  task automatic plan_expect(input int w, input int st);
    int s = st;
    int rec [DEC];
    for (int i = 0; i < TOTAL; i++) begin
      int e = int'((rows[w-1-i] >> (4*s)) & 128'hF);
      if (i >= TB) rec[i-TB] = (s >> 1) & 15;
      s = (s & 1) * 16 + e;
    end
    for (int j = 0; j < DEC; j++) exp_nib[j] = rec[DEC-1-j];
  endtask

  task automatic tick(input bit v, input bit st, input int ss);
    logic [63:0] d;
    @(negedge clk);
    d = {$urandom, $urandom};
    acs_valid = v;
    acs_dec   = d;
    tb_start  = st;
    tb_state  = 5'(ss);
    if (st && !tb_busy) begin
      plan_expect(nrows, ss);
      sess_tag = cur_tag;
    end
    if (v) begin
      if (!half) begin held = d; half = 1'b1; end
      else begin rows[nrows] = b_merge(held, d); nrows++; half = 1'b0; end
    end
  endtask

  task automatic wait_idle(input bit v);
    int n = 0;
    tick(v, 1'b0, 0);
    while (tb_busy && n < 500) begin tick(v, 1'b0, 0); n++; end
    tick(1'b0, 1'b0, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bits_valid) begin
        if (got < DEC) chk(bits == 4'(exp_nib[got]), {sess_tag, " R7 nibble"}, int'(bits), exp_nib[got]);
        else chk(1'b0, "R7 extra nibble", got + 1, DEC);
        got++;
      end
      if (prev_busy && !tb_busy) begin
        chk(got == DEC, "R7 nibble count", got, DEC);
        got = 0;
      end
      prev_busy = tb_busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tb_busy == 1'b0, "R9 busy after reset", int'(tb_busy), 0);
    chk(bits_valid == 1'b0, "R9 valid after reset", int'(bits_valid), 0);

    // directed: pairing from reset, fill then walk from state 0
    cur_tag = "R1 R5 R6 R9";
    for (int i = 0; i < 28; i++) tick(1'b1, 1'b0, 0);
    tick(1'b0, 1'b1, 0);
    wait_idle(1'b0);

    // directed: rows arriving at full rate during the walk
    cur_tag = "R3";
    tick(1'b1, 1'b1, 31);
    wait_idle(1'b1);

    // directed: requests while busy carry another state
    cur_tag = "R8";
    tick(1'b0, 1'b1, 5);
    for (int i = 0; i < 40; i++) tick(1'b0, tb_busy, 22);
    wait_idle(1'b0);

    // random traffic, wrapping the cyclic store many times
    cur_tag = "R2 R4";
    for (int i = 0; i < 3000; i++) begin
      bit v  = ($urandom % 4) != 0;
      bit st = tb_busy ? (($urandom % 8) == 0) : (($urandom % 3) == 0);
      tick(v, st, int'($urandom % 32));
    end
    wait_idle(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule